// File: doc/BRIEF.md
# SDRAM Refresh and Activity Sequencer

This block sits ahead of an SDRAM command engine. It decides when the memory may be brought up, when a refresh is due, and whether the SDRAM clock should run. Configuration arrives through two write strobes. One carries the enable bit, the clock-stop policy bit and the CAS-latency code. The other carries a 16-bit refresh interval counted in bus clock cycles.

After the enable bit is set, the sequencer raises an initialization request and holds it until the command engine acknowledges it. It then counts the refresh interval and raises a refresh request each time the interval elapses. Requests that have not yet been acknowledged are held in a small saturating backlog counter, so none is lost. Clearing the enable bit parks the block in an inactive state. Setting the bit again starts a fresh initialization before refresh resumes.

A standby input, the clock-stop policy and the enable bit together decide the clock enable for the SDRAM clock. The CAS-latency code is decoded into a cycle count. Reserved codes fall back to latency 2 and set a sticky error flag.

Top module: `sdram_refresh_seq`

## Requirements
- R1: After reset, init_req, rfsh_req, rfsh_pend and cfg_err are 0, sdclk_en is 1 and cas_lat is 2. The refresh interval register holds 256, so the first refresh after the first initialization comes 256 cycles after the initialization acknowledge.
- R2: While running, a refresh becomes due every `interval` clock cycles. With the count started after the acknowledge edge, the first rfsh_req is seen after exactly `interval` edges.
- R3: A written interval of 0 or 1 is stored as 2, giving a refresh period of 2 cycles.
- R4: init_req is raised only while the enable bit (cfg_wr_en) is 1. It stays high until init_ack is sampled high.
- R5: Clearing the enable bit after initialization drops the block into an inactive state with no init_req and no rfsh_req. Setting the bit again raises init_req before any refresh request.
- R6: sdclk_en is 0 during standby. With clock-stop bit 0, it is 1 at all other times. With clock-stop bit 1, it is also 0 while the enable bit is 0.
- R7: CAS code 2'b11 gives cas_lat 3. Code 2'b10 gives cas_lat 2. Reserved codes 2'b00 and 2'b01 give cas_lat 2 and set cfg_err, which then stays 1 until reset.
- R8: rfsh_req stays high until rfsh_ack. The 3-bit rfsh_pend counts unacknowledged refreshes, saturates at 7, and drops by one for each ack.
- R9: A refresh falling due in the same cycle as an ack leaves rfsh_pend unchanged.
- R10: The refresh timer is held, and rfsh_pend is cleared, while the block is uninitialized, inactive or in standby. After standby ends, the next rfsh_req comes a full interval later.
- R11: An interval written while the timer is counting takes effect only at the next reload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for enable, clock-stop and CAS code |
| cfg_wr_en | input | 1 | Enable bit value |
| cfg_wr_clk_stop | input | 1 | Clock-stop policy bit value |
| cfg_wr_cas | input | 2 | CAS-latency code value |
| ival_wr | input | 1 | Write strobe for the refresh interval |
| ival_wdata | input | 16 | Refresh interval in bus cycles |
| standby | input | 1 | System standby indication |
| init_ack | input | 1 | Initialization done, from command engine |
| rfsh_ack | input | 1 | One refresh issued, from command engine |
| init_req | output | 1 | Initialization request |
| rfsh_req | output | 1 | Refresh request (backlog non-zero) |
| rfsh_pend | output | 3 | Number of unacknowledged refreshes |
| sdclk_en | output | 1 | SDRAM clock enable |
| cas_lat | output | 2 | Decoded CAS latency in cycles |
| cfg_err | output | 1 | Sticky reserved-CAS-code flag |

## Verification
Two events can fall in the same cycle: the timer expiring, which adds to the backlog, and the command engine's acknowledge, which removes from it. The bench fills the backlog to 7 with a 2-cycle interval. It then holds rfsh_ack for four consecutive cycles. Exactly two expiries land in that window, whatever the phase. The result must therefore be 5, which is only reached if each coinciding expiry and ack cancel and saturation does not swallow an increment taken together with a decrement.

// File: rtl/sdrs_pkg.sv
package sdrs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INIT = 2'd1,
    ST_RUN  = 2'd2,
    ST_OFF  = 2'd3
  } seq_st_e;

  localparam logic [1:0] CAS_CODE_L3 = 2'b11;
  localparam logic [1:0] CAS_CODE_L2 = 2'b10;
endpackage

// File: rtl/sdrs_cfg.sv
module sdrs_cfg #(
  parameter int IW       = 16,
  parameter int RST_IVAL = 256,
  parameter int MIN_IVAL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          wr_en,
  input  logic          wr_clk_stop,
  input  logic [1:0]    wr_cas,
  input  logic          ival_wr,
  input  logic [IW-1:0] ival_wdata,
  output logic          en_q,
  output logic          clk_stop_q,
  output logic [1:0]    cas_lat,
  output logic          cfg_err,
  output logic [IW-1:0] ival_q
);
  import sdrs_pkg::*;

  localparam logic [IW-1:0] IVAL_RST = IW'(RST_IVAL);
  localparam logic [IW-1:0] IVAL_MIN = IW'(MIN_IVAL);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q       <= 1'b0;
      clk_stop_q <= 1'b0;
      cas_lat    <= 2'd2;
      cfg_err    <= 1'b0;
      ival_q     <= IVAL_RST;
    end else begin
      if (cfg_wr) begin
        en_q       <= wr_en;
        clk_stop_q <= wr_clk_stop;
        cas_lat    <= (wr_cas == CAS_CODE_L3) ? 2'd3 : 2'd2;
        if (wr_cas != CAS_CODE_L3 && wr_cas != CAS_CODE_L2)
          cfg_err <= 1'b1;
      end
      if (ival_wr)
        ival_q <= (ival_wdata < IVAL_MIN) ? IVAL_MIN : ival_wdata;
    end
  end
endmodule

// File: rtl/sdrs_timer.sv
module sdrs_timer #(
  parameter int IW       = 16,
  parameter int RST_IVAL = 256
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [IW-1:0] ival,
  output logic          expire
);
  localparam logic [IW-1:0] ONE = IW'(1);

  logic [IW-1:0] cnt;

  assign expire = run && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= IW'(RST_IVAL);
    else if (!run || expire)
      cnt <= ival;
    else
      cnt <= cnt - ONE;
  end
endmodule

// File: rtl/sdrs_pend.sv
module sdrs_pend #(
  parameter int PW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          inc,
  input  logic          ack,
  output logic [PW-1:0] cnt
);
  localparam logic [PW:0] SAT = (PW+1)'((1 << PW) - 1);

  logic [PW:0] nxt;
  logic        dec;

  assign dec = ack && (cnt != '0);

  always_comb begin
    nxt = {1'b0, cnt} + {{PW{1'b0}}, inc} - {{PW{1'b0}}, dec};
    if (nxt > SAT)
      nxt = SAT;
  end

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else
      cnt <= nxt[PW-1:0];
  end
endmodule

// File: rtl/sdram_refresh_seq.sv
module sdram_refresh_seq #(
  parameter int IW       = 16,
  parameter int PW       = 3,
  parameter int RST_IVAL = 256,
  parameter int MIN_IVAL = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic          cfg_wr_en,
  input  logic          cfg_wr_clk_stop,
  input  logic [1:0]    cfg_wr_cas,
  input  logic          ival_wr,
  input  logic [IW-1:0] ival_wdata,
  input  logic          standby,
  input  logic          init_ack,
  input  logic          rfsh_ack,
  output logic          init_req,
  output logic          rfsh_req,
  output logic [PW-1:0] rfsh_pend,
  output logic          sdclk_en,
  output logic [1:0]    cas_lat,
  output logic          cfg_err
);
  import sdrs_pkg::*;

  logic          en_q;
  logic          clk_stop_q;
  logic [IW-1:0] ival_q;
  logic          run;
  logic          expire;
  seq_st_e       state;
  seq_st_e       state_nxt;

  sdrs_cfg #(.IW(IW), .RST_IVAL(RST_IVAL), .MIN_IVAL(MIN_IVAL)) u_cfg (
    .clk(clk), .rst(rst),
    .cfg_wr(cfg_wr), .wr_en(cfg_wr_en), .wr_clk_stop(cfg_wr_clk_stop),
    .wr_cas(cfg_wr_cas), .ival_wr(ival_wr), .ival_wdata(ival_wdata),
    .en_q(en_q), .clk_stop_q(clk_stop_q), .cas_lat(cas_lat),
    .cfg_err(cfg_err), .ival_q(ival_q)
  );

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE: if (en_q) state_nxt = ST_INIT;
      ST_INIT: if (!en_q) state_nxt = ST_IDLE;
               else if (init_ack) state_nxt = ST_RUN;
      ST_RUN:  if (!en_q) state_nxt = ST_OFF;
      ST_OFF:  if (en_q) state_nxt = ST_INIT;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      sdclk_en <= 1'b1;
    end else begin
      state    <= state_nxt;
      sdclk_en <= !standby && !(clk_stop_q && !en_q);
    end
  end

  assign run      = (state == ST_RUN) && !standby;
  assign init_req = (state == ST_INIT);

  sdrs_timer #(.IW(IW), .RST_IVAL(RST_IVAL)) u_timer (
    .clk(clk), .rst(rst), .run(run), .ival(ival_q), .expire(expire)
  );

  sdrs_pend #(.PW(PW)) u_pend (
    .clk(clk), .rst(rst), .clr(!run), .inc(expire), .ack(rfsh_ack),
    .cnt(rfsh_pend)
  );

  assign rfsh_req = (rfsh_pend != '0);
endmodule

// File: rtl/sdrs_chk.sv
module sdrs_chk #(
  parameter int PW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          en_q,
  input logic          standby,
  input logic          run,
  input logic          rfsh_ack,
  input logic          init_req,
  input logic          rfsh_req,
  input logic [PW-1:0] rfsh_pend,
  input logic          sdclk_en,
  input logic          cfg_err
);
  localparam logic [PW-1:0] SAT = '1;

  // R4
  init_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !init_req);

  // R6
  standby_clk_off_chk: assert property (@(posedge clk) disable iff (rst)
    standby |=> !sdclk_en);

  // R10
  standby_no_rfsh_chk: assert property (@(posedge clk) disable iff (rst)
    standby |=> !rfsh_req);

  // R8
  rfsh_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rfsh_req && !rfsh_ack && run) |=> rfsh_req);

  // R8
  pend_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (rfsh_pend == SAT && !rfsh_ack && run) |=> (rfsh_pend == SAT));

  // R7
  cfg_err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_err |=> cfg_err);
endmodule

bind sdram_refresh_seq sdrs_chk #(.PW(PW)) u_sdrs_chk (
  .clk(clk), .rst(rst), .en_q(en_q), .standby(standby), .run(run),
  .rfsh_ack(rfsh_ack), .init_req(init_req), .rfsh_req(rfsh_req),
  .rfsh_pend(rfsh_pend), .sdclk_en(sdclk_en), .cfg_err(cfg_err)
);

// File: tb/tb_sdram_refresh_seq.sv
module tb_sdram_refresh_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0, cfg_wr_en = 1'b0, cfg_wr_clk_stop = 1'b0;
  logic [1:0]  cfg_wr_cas = 2'b10;
  logic        ival_wr = 1'b0;
  logic [15:0] ival_wdata = 16'd0;
  logic        standby = 1'b0, init_ack = 1'b0, rfsh_ack = 1'b0;
  logic        init_req, rfsh_req, sdclk_en, cfg_err;
  logic [2:0]  rfsh_pend;
  logic [1:0]  cas_lat;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // {written interval, expected period}
  localparam logic [31:0] VECS [0:5] = '{
    {16'd0,  16'd2},  {16'd1, 16'd2}, {16'd2, 16'd2},
    {16'd3,  16'd3},  {16'd7, 16'd7}, {16'd40, 16'd40}
  };

  always #10 clk = ~clk;

  sdram_refresh_seq dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wr_en(cfg_wr_en),
    .cfg_wr_clk_stop(cfg_wr_clk_stop), .cfg_wr_cas(cfg_wr_cas),
    .ival_wr(ival_wr), .ival_wdata(ival_wdata), .standby(standby),
    .init_ack(init_ack), .rfsh_ack(rfsh_ack), .init_req(init_req),
    .rfsh_req(rfsh_req), .rfsh_pend(rfsh_pend), .sdclk_en(sdclk_en),
    .cas_lat(cas_lat), .cfg_err(cfg_err)
  );

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cfg(logic en, logic cs, logic [1:0] cas);
    cfg_wr = 1'b1; cfg_wr_en = en; cfg_wr_clk_stop = cs; cfg_wr_cas = cas;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic wr_ival(logic [15:0] v);
    ival_wr = 1'b1; ival_wdata = v;
    tick();
    ival_wr = 1'b0;
  endtask

  task automatic wait_init(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 50; i++) begin
      if (init_req) begin seen = 1'b1; break; end
      tick();
    end
  endtask

  // ack init, count edges after the ack edge until rfsh_req
  task automatic ack_init_measure(output int k);
    init_ack = 1'b1;
    tick();
    init_ack = 1'b0;
    k = 0;
    do begin tick(); k++; end while (!rfsh_req && k < 70000);
  endtask

  // ack the pending refresh, count edges until the next one
  task automatic ack_rf_measure(output int k, input bit do_wr, input logic [15:0] wv);
    rfsh_ack = 1'b1;
    k = 0;
    do begin
      tick(); k++;
      rfsh_ack = 1'b0;
      ival_wr = do_wr && (k == 2);
      ival_wdata = wv;
    end while (!rfsh_req && k < 70000);
    ival_wr = 1'b0;
  endtask

  initial begin
    int k;
    bit seen;
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk("R1 init_req", init_req, 0);
    chk("R1 rfsh_req", rfsh_req, 0);
    chk("R1 rfsh_pend", rfsh_pend, 0);
    chk("R1 sdclk_en", sdclk_en, 1);
    chk("R1 cas_lat", cas_lat, 2);
    chk("R1 cfg_err", cfg_err, 0);
    tick(5);
    chk("R4 no init while disabled", init_req, 0);

    // R4 init request held until ack; R1 default interval
    cfg(1'b1, 1'b0, 2'b10);
    wait_init(seen);
    chk("R4 init_req raised", seen, 1);
    tick(3);
    chk("R4 init_req held", init_req, 1);
    ack_init_measure(k);
    chk("R1 default period 256", k, 256);

    // R2/R3 vector table
    foreach (VECS[i]) begin
      cfg(1'b0, 1'b0, 2'b10);
      tick(3);
      wr_ival(VECS[i][31:16]);
      cfg(1'b1, 1'b0, 2'b10);
      wait_init(seen);
      ack_init_measure(k);
      chk((VECS[i][31:16] < 2) ? "R3 clamp period" : "R2 period", k, int'(VECS[i][15:0]));
    end

    // R11 mid-count write takes effect at next reload
    ack_rf_measure(k, 1'b1, 16'd10);
    chk("R11 old interval kept", k, 40);
    ack_rf_measure(k, 1'b0, 16'd0);
    chk("R11 new interval used", k, 10);

    // R10/R6 standby
    standby = 1'b1;
    tick(2);
    chk("R6 clock off in standby", sdclk_en, 0);
    chk("R10 pend cleared in standby", rfsh_req, 0);
    tick(30);
    chk("R10 no refresh in standby", rfsh_req, 0);
    standby = 1'b0;
    k = 0;
    do begin tick(); k++; end while (!rfsh_req && k < 70000);
    chk("R10 full interval after standby", k, 10);
    chk("R6 clock back on", sdclk_en, 1);

    // R8 saturation, R9 expiry with ack
    wr_ival(16'd2);
    tick(30);
    chk("R8 pend saturates", rfsh_pend, 7);
    chk("R8 req held without ack", rfsh_req, 1);
    rfsh_ack = 1'b1;
    tick(4);
    rfsh_ack = 1'b0;
    chk("R9 ack and expiry coincide", rfsh_pend, 5);

    // R7 CAS decode and sticky error
    cfg(1'b1, 1'b0, 2'b11);
    chk("R7 code 11 latency", cas_lat, 3);
    chk("R7 no error", cfg_err, 0);
    cfg(1'b1, 1'b0, 2'b01);
    chk("R7 reserved latency", cas_lat, 2);
    chk("R7 error set", cfg_err, 1);
    cfg(1'b1, 1'b0, 2'b10);
    chk("R7 error sticky", cfg_err, 1);
    cfg(1'b1, 1'b0, 2'b00);
    chk("R7 code 00 latency", cas_lat, 2);

    // R5 inactive state, R6 clock policy
    cfg(1'b0, 1'b0, 2'b10);
    tick(4);
    seen = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (rfsh_req || init_req) seen = 1'b1;
      tick();
    end
    chk("R5 quiet while inactive", seen, 0);
    chk("R6 clock runs when inactive, stop=0", sdclk_en, 1);
    cfg(1'b0, 1'b1, 2'b10);
    tick(2);
    chk("R6 clock stops when inactive, stop=1", sdclk_en, 0);
    cfg(1'b1, 1'b1, 2'b10);
    wait_init(seen);
    chk("R5 re-init request", seen, 1);
    chk("R5 no refresh before re-init", rfsh_req, 0);
    chk("R6 clock on when enabled, stop=1", sdclk_en, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule